// File: doc/BRIEF.md
# Isochronous IN Endpoint Transmit Buffer

This block is the transmit side of one isochronous IN endpoint in a USB device controller. A processor or a DMA engine writes packet bytes, one per cycle, into a pair of packet-sized ping-pong banks. A bank is committed for sending in one of two ways:

- it fills to the full packet size, or
- software requests a short packet through the status register.

When the host sends an IN token, the block streams the oldest committed packet one byte per cycle and then marks the end of the packet. If the block has nothing to send, it answers with an empty packet or a NAK, depending on the completion flag.

A small status register reports four things:

- whether the buffer needs service, meaning one or fewer packets are committed,
- a completion flag that is cleared by writing one,
- the pending short-packet request,
- a sticky overflow flag.

The completion flag drives an interrupt request that can be masked, so that DMA can keep both banks filled without processor involvement. The serial engine, CRC, PID encoding and the DMA engine lie outside this block.

Top module: `iso_in_ep_tx`

## Requirements
- R1: After reset, `csr_rdata` reads 0x01: bit 0 is the service flag, bit 1 the completion flag, bit 2 the short-request flag, bit 3 the overflow flag and bits 7:4 read zero. While reset is held, `irq`, `tx_valid`, `tx_end` and `tx_nak` are 0.
- R2: The service flag (bit 0) reads 1 while zero or one packets are committed and reads 0 while two are committed.
- R3: A packet commits when exactly `PKT_BYTES` bytes have been written to it. Further bytes go into the other bank.
- R4: A `csr_we` cycle with `csr_wdata` bit 2 set raises the short request (bit 2). The request is served in the next cycle that has no data write and a free bank. Serving it commits the bytes written so far, possibly zero, as a packet of that length, and the request then self-clears. While both banks are committed, the request stays pending.
- R5: An IN token is taken only while the sender is idle. When a packet is committed, its bytes appear on `tx_data`, with `tx_valid` high, in the order they were written, one per cycle, starting in the cycle after the token. `tx_end` is high for one cycle right after the last byte, or in the cycle after the token if the packet is empty.
- R6: The completion flag (bit 1) sets in the cycle after `tx_end` of a committed packet. Writing 1 to bit 1 clears it. Writing 0 leaves it unchanged, and a new completion wins over a clear in the same cycle.
- R7: `irq` equals the completion flag when `irq_en` is 1, and is 0 when `irq_en` is 0.
- R8: A set completion flag does not stop the sending of a packet that is already committed.
- R9: An IN token that arrives while the completion flag is set and no packet is committed is answered by `tx_nak` high for exactly the one cycle after the token.
- R10: An IN token that arrives while the completion flag is clear and no packet is committed gets an empty packet: `tx_end` alone in the cycle after the token. The status register is not changed.
- R11: A data write while both banks are committed is dropped and sets the sticky overflow flag (bit 3). Writing 1 to bit 3 clears that flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Data byte write strobe |
| wr_data | input | 8 | Data byte |
| csr_we | input | 1 | Status register write strobe |
| csr_wdata | input | 4 | Write data: bit 1 clears completion, bit 2 requests short packet, bit 3 clears overflow |
| csr_rdata | output | 8 | Status register read value |
| irq_en | input | 1 | Completion interrupt enable |
| irq | output | 1 | Endpoint interrupt request |
| in_token | input | 1 | IN token request, one-cycle pulse |
| tx_valid | output | 1 | Packet byte valid |
| tx_data | output | 8 | Packet byte |
| tx_end | output | 1 | End of packet, one cycle |
| tx_nak | output | 1 | NAK response, one cycle |

## Verification
Timing of the results:

- Packet bytes are due starting in the first cycle after the edge that samples the token.
- `tx_end` or `tx_nak` is due one cycle after the last byte, or one cycle after the token when there is no data.
- The completion flag and the freed bank become visible one cycle after `tx_end`.
- A short request commits two edges after its register write.

The bench drives its inputs on falling edges and samples on falling edges. During a token it samples every cycle, so each byte and end marker is checked in the cycle where it is due. Status register checks wait three cycles after each operation, so every pending commit or flag update has settled before the check.

// File: rtl/iso_in_pkg.sv
package iso_in_pkg;

    // status register bit positions (software decodes these)
    localparam int CSR_RD_W  = 8;
    localparam int CSR_WR_W  = 4;
    localparam int BIT_SVC   = 0;
    localparam int BIT_DONE  = 1;
    localparam int BIT_SHORT = 2;
    localparam int BIT_OVF   = 3;

    typedef enum logic [1:0] {
        SND_IDLE = 2'd0,
        SND_DATA = 2'd1,
        SND_END  = 2'd2,
        SND_NAK  = 2'd3
    } snd_state_e;

    typedef struct packed {
        logic ovf;
        logic short_pend;
        logic done;
        logic svc;
    } ep_flags_t;

    function automatic logic svc_from_count(input logic [1:0] n_commit);
        return n_commit < 2'd2;
    endfunction

    function automatic logic [CSR_RD_W-1:0] pack_csr(input ep_flags_t f);
        logic [CSR_RD_W-1:0] v;
        v = '0;
        v[BIT_SVC]   = f.svc;
        v[BIT_DONE]  = f.done;
        v[BIT_SHORT] = f.short_pend;
        v[BIT_OVF]   = f.ovf;
        return v;
    endfunction

endpackage

// File: rtl/iso_in_bankmem.sv
module iso_in_bankmem #(
    parameter int PKT_BYTES = 256,
    parameter int AW        = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic          wbank,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic          rbank,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] bank_out [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [7:0] cells [PKT_BYTES];

        always_ff @(posedge clk) begin
            if (we && (wbank == 1'(b))) begin
                cells[waddr] <= wdata;
            end
        end

        assign bank_out[b] = cells[raddr];
    end

    assign rdata = bank_out[rbank];

endmodule

// File: rtl/iso_in_queue.sv
module iso_in_queue
    import iso_in_pkg::*;
#(
    parameter int PKT_BYTES = 256,
    parameter int AW        = 8,
    parameter int CW        = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_valid,
    input  logic          short_req,
    input  logic          pop,
    output logic          mem_we,
    output logic          mem_wbank,
    output logic [AW-1:0] mem_waddr,
    output logic          send_bank,
    output logic [CW-1:0] send_len,
    output logic [1:0]    n_commit,
    output logic          short_pend,
    output logic          drop_evt
);

    logic [CW-1:0] fill_cnt;
    logic          fill_bank;
    logic          send_bank_q;
    logic [1:0]    n_q;
    logic [CW-1:0] len_q [2];
    logic          pend_q;

    logic full, accept, last_byte, short_commit, commit;

    always_comb begin
        full         = (n_q == 2'd2);
        accept       = wr_valid && !full;
        last_byte    = accept && (fill_cnt == CW'(PKT_BYTES - 1));
        short_commit = pend_q && !wr_valid && !full;
        commit       = last_byte || short_commit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_cnt    <= '0;
            fill_bank   <= 1'b0;
            send_bank_q <= 1'b0;
            n_q         <= 2'd0;
            pend_q      <= 1'b0;
            for (int i = 0; i < 2; i++) begin
                len_q[i] <= '0;
            end
        end else begin
            if (accept) begin
                fill_cnt <= last_byte ? '0 : fill_cnt + CW'(1);
            end else if (short_commit) begin
                fill_cnt <= '0;
            end
            if (commit) begin
                len_q[fill_bank] <= last_byte ? CW'(PKT_BYTES) : fill_cnt;
                fill_bank        <= ~fill_bank;
            end
            if (pop) begin
                send_bank_q <= ~send_bank_q;
            end
            case ({commit, pop})
                2'b10:   n_q <= n_q + 2'd1;
                2'b01:   n_q <= n_q - 2'd1;
                default: n_q <= n_q;
            endcase
            if (short_req) begin
                pend_q <= 1'b1;
            end else if (commit) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign mem_we     = accept;
    assign mem_wbank  = fill_bank;
    assign mem_waddr  = fill_cnt[AW-1:0];
    assign send_bank  = send_bank_q;
    assign send_len   = len_q[send_bank_q];
    assign n_commit   = n_q;
    assign short_pend = pend_q;
    assign drop_evt   = wr_valid && full;

endmodule

// File: rtl/iso_in_sender.sv
module iso_in_sender
    import iso_in_pkg::*;
#(
    parameter int AW = 8,
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_token,
    input  logic [1:0]    n_commit,
    input  logic          done,
    input  logic [CW-1:0] send_len,
    input  logic [7:0]    rdata,
    output logic [AW-1:0] raddr,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_end,
    output logic          tx_nak,
    output logic          pop
);

    snd_state_e    st;
    logic [CW-1:0] idx;
    logic          real_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SND_IDLE;
            idx    <= '0;
            real_q <= 1'b0;
        end else begin
            case (st)
                SND_IDLE: begin
                    if (in_token) begin
                        idx <= '0;
                        if (n_commit != 2'd0) begin
                            real_q <= 1'b1;
                            st     <= (send_len == '0) ? SND_END : SND_DATA;
                        end else if (done) begin
                            real_q <= 1'b0;
                            st     <= SND_NAK;
                        end else begin
                            real_q <= 1'b0;
                            st     <= SND_END;
                        end
                    end
                end
                SND_DATA: begin
                    if (idx == send_len - CW'(1)) begin
                        st <= SND_END;
                    end else begin
                        idx <= idx + CW'(1);
                    end
                end
                SND_END: st <= SND_IDLE;
                default: st <= SND_IDLE;
            endcase
        end
    end

    assign raddr    = idx[AW-1:0];
    assign tx_valid = (st == SND_DATA);
    assign tx_data  = rdata;
    assign tx_end   = (st == SND_END);
    assign tx_nak   = (st == SND_NAK);
    assign pop      = (st == SND_END) && real_q;

endmodule

// File: rtl/iso_in_ep_tx.sv
module iso_in_ep_tx
    import iso_in_pkg::*;
#(
    parameter int PKT_BYTES = 256
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_valid,
    input  logic [7:0]          wr_data,
    input  logic                csr_we,
    input  logic [CSR_WR_W-1:0] csr_wdata,
    output logic [CSR_RD_W-1:0] csr_rdata,
    input  logic                irq_en,
    output logic                irq,
    input  logic                in_token,
    output logic                tx_valid,
    output logic [7:0]          tx_data,
    output logic                tx_end,
    output logic                tx_nak
);

    localparam int AW = $clog2(PKT_BYTES);
    localparam int CW = $clog2(PKT_BYTES + 1);

    logic          mem_we, mem_wbank, send_bank, short_pend, drop_evt, pop;
    logic [AW-1:0] mem_waddr, raddr;
    logic [CW-1:0] send_len;
    logic [1:0]    n_commit;
    logic [7:0]    rdata;
    logic          done_q, ovf_q;
    logic          short_req;
    ep_flags_t     flags;

    assign short_req = csr_we && csr_wdata[BIT_SHORT];

    iso_in_bankmem #(.PKT_BYTES(PKT_BYTES), .AW(AW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .wbank (mem_wbank),
        .waddr (mem_waddr),
        .wdata (wr_data),
        .rbank (send_bank),
        .raddr (raddr),
        .rdata (rdata)
    );

    iso_in_queue #(.PKT_BYTES(PKT_BYTES), .AW(AW), .CW(CW)) u_queue (
        .clk        (clk),
        .rst        (rst),
        .wr_valid   (wr_valid),
        .short_req  (short_req),
        .pop        (pop),
        .mem_we     (mem_we),
        .mem_wbank  (mem_wbank),
        .mem_waddr  (mem_waddr),
        .send_bank  (send_bank),
        .send_len   (send_len),
        .n_commit   (n_commit),
        .short_pend (short_pend),
        .drop_evt   (drop_evt)
    );

    iso_in_sender #(.AW(AW), .CW(CW)) u_send (
        .clk      (clk),
        .rst      (rst),
        .in_token (in_token),
        .n_commit (n_commit),
        .done     (done_q),
        .send_len (send_len),
        .rdata    (rdata),
        .raddr    (raddr),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_end   (tx_end),
        .tx_nak   (tx_nak),
        .pop      (pop)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            if (pop) begin
                done_q <= 1'b1;
            end else if (csr_we && csr_wdata[BIT_DONE]) begin
                done_q <= 1'b0;
            end
            if (drop_evt) begin
                ovf_q <= 1'b1;
            end else if (csr_we && csr_wdata[BIT_OVF]) begin
                ovf_q <= 1'b0;
            end
        end
    end

    always_comb begin
        flags.svc        = svc_from_count(n_commit);
        flags.done       = done_q;
        flags.short_pend = short_pend;
        flags.ovf        = ovf_q;
    end

    assign csr_rdata = pack_csr(flags);
    assign irq       = done_q && irq_en;

endmodule

// File: rtl/iso_in_ep_tx_chk.sv
module iso_in_ep_tx_chk
    import iso_in_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                wr_valid,
    input logic                csr_we,
    input logic [CSR_WR_W-1:0] csr_wdata,
    input logic [CSR_RD_W-1:0] csr_rdata,
    input logic                irq_en,
    input logic                irq,
    input logic                tx_valid,
    input logic                tx_end,
    input logic                tx_nak
);

    // R11
    drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !csr_rdata[BIT_SVC]) |=> csr_rdata[BIT_OVF]);

    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (csr_rdata[BIT_DONE] && !(csr_we && csr_wdata[BIT_DONE])) |=> csr_rdata[BIT_DONE]);

    // R6
    done_after_end_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(csr_rdata[BIT_DONE]) |-> $past(tx_end));

    // R9
    nak_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
        tx_nak |-> $past(csr_rdata[BIT_DONE]));

    // R5
    one_response_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tx_valid, tx_end, tx_nak}));

    // R7
    irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);

endmodule

bind iso_in_ep_tx iso_in_ep_tx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_valid  (wr_valid),
    .csr_we    (csr_we),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .irq_en    (irq_en),
    .irq       (irq),
    .tx_valid  (tx_valid),
    .tx_end    (tx_end),
    .tx_nak    (tx_nak)
);

// File: tb/iso_in_ep_tx_test.sv
module iso_in_ep_tx_test;

    localparam int PKT = 8;

    localparam logic [2:0] OP_WR    = 3'd0;
    localparam logic [2:0] OP_WRX   = 3'd1;
    localparam logic [2:0] OP_SHORT = 3'd2;
    localparam logic [2:0] OP_TOK   = 3'd3;
    localparam logic [2:0] OP_CSR   = 3'd4;
    localparam logic [1:0] K_NONE   = 2'd0;
    localparam logic [1:0] K_DATA   = 2'd1;
    localparam logic [1:0] K_NAK    = 2'd2;
    localparam logic [1:0] K_EMPTY  = 2'd3;

    typedef struct packed {
        logic [2:0] op;
        logic [7:0] arg;
        logic [1:0] kind;
        logic [3:0] csr;   // {ovf, short, done, svc}
        logic       irq;
    } row_t;

    localparam int NROWS = 20;
    localparam row_t TBL [NROWS] = '{
        '{OP_TOK,   8'd0,  K_EMPTY, 4'b0001, 1'b0},  // R10
        '{OP_WR,    8'd8,  K_NONE,  4'b0001, 1'b0},  // R3
        '{OP_WR,    8'd3,  K_NONE,  4'b0001, 1'b0},
        '{OP_SHORT, 8'd0,  K_NONE,  4'b0000, 1'b0},  // R4 R2
        '{OP_WRX,   8'd2,  K_NONE,  4'b1000, 1'b0},  // R11
        '{OP_TOK,   8'd8,  K_DATA,  4'b1011, 1'b1},  // R5 R6 R7
        '{OP_TOK,   8'd3,  K_DATA,  4'b1011, 1'b1},  // R8
        '{OP_TOK,   8'd0,  K_NAK,   4'b1011, 1'b1},  // R9
        '{OP_CSR,   8'h0A, K_NONE,  4'b0001, 1'b0},  // R6 R11
        '{OP_TOK,   8'd0,  K_EMPTY, 4'b0001, 1'b0},  // R10
        '{OP_WR,    8'd5,  K_NONE,  4'b0001, 1'b0},
        '{OP_WR,    8'd8,  K_NONE,  4'b0001, 1'b0},  // R3
        '{OP_SHORT, 8'd0,  K_NONE,  4'b0000, 1'b0},  // R2
        '{OP_TOK,   8'd8,  K_DATA,  4'b0011, 1'b1},
        '{OP_TOK,   8'd5,  K_DATA,  4'b0011, 1'b1},
        '{OP_SHORT, 8'd0,  K_NONE,  4'b0011, 1'b1},  // R4 zero length
        '{OP_CSR,   8'h02, K_NONE,  4'b0001, 1'b0},
        '{OP_TOK,   8'd0,  K_DATA,  4'b0011, 1'b1},
        '{OP_CSR,   8'h00, K_NONE,  4'b0011, 1'b1},  // R6 write 0
        '{OP_TOK,   8'd0,  K_NAK,   4'b0011, 1'b1}   // R9
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       csr_we = 1'b0;
    logic [3:0] csr_wdata = 4'h0;
    logic [7:0] csr_rdata;
    logic       irq_en = 1'b1;
    logic       irq;
    logic       in_token = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_end;
    logic       tx_nak;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [7:0] wr_seq = 8'd0;
    logic [7:0] rd_seq = 8'd0;

    always #5 clk = ~clk;

    iso_in_ep_tx #(.PKT_BYTES(PKT)) uut (
        .clk       (clk),
        .rst       (rst),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .csr_we    (csr_we),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .irq_en    (irq_en),
        .irq       (irq),
        .in_token  (in_token),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_end    (tx_end),
        .tx_nak    (tx_nak)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_bytes(input int n, input bit dropped);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_valid = 1'b1;
            if (dropped) begin
                wr_data = 8'hEE;
            end else begin
                wr_data = wr_seq;
                wr_seq  = wr_seq + 8'd1;
            end
        end
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic csr_write(input logic [3:0] v);
        @(negedge clk);
        csr_we    = 1'b1;
        csr_wdata = v;
        @(negedge clk);
        csr_we    = 1'b0;
        csr_wdata = 4'h0;
    endtask

    // issues a token and collects the response, checking byte order
    task automatic token(output int nbytes, output bit got_end, output bit got_nak,
                         output int bad_data);
        nbytes = 0; got_end = 0; got_nak = 0; bad_data = 0;
        @(negedge clk);
        in_token = 1'b1;
        @(negedge clk);
        in_token = 1'b0;
        for (int i = 0; i < 2 * PKT + 4; i++) begin
            if (tx_valid) begin
                if (tx_data != rd_seq) bad_data = bad_data + 1;
                rd_seq = rd_seq + 8'd1;
                nbytes = nbytes + 1;
            end
            if (tx_end) begin
                got_end = 1;
                break;
            end
            if (tx_nak) begin
                got_nak = 1;
                @(negedge clk);
                if (tx_nak) bad_data = bad_data + 1;  // pulse must be one cycle
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        int nb, bad;
        bit ge, gn;

        idle(3);
        // R1 reset state
        check(csr_rdata == 8'h01, "R1 csr after reset", csr_rdata, 8'h01);
        check({irq, tx_valid, tx_end, tx_nak} == 4'b0, "R1 outputs in reset",
              {irq, tx_valid, tx_end, tx_nak}, 0);
        @(negedge clk);
        rst = 1'b0;
        idle(2);

        for (int r = 0; r < NROWS; r++) begin
            case (TBL[r].op)
                OP_WR:    write_bytes(int'(TBL[r].arg), 1'b0);
                OP_WRX:   write_bytes(int'(TBL[r].arg), 1'b1);
                OP_SHORT: csr_write(4'b0100);
                OP_CSR:   csr_write(TBL[r].arg[3:0]);
                default: begin
                    token(nb, ge, gn, bad);
                    if (TBL[r].kind == K_NAK) begin
                        check(gn && !ge && nb == 0 && bad == 0, "R9 NAK response",
                              {gn, ge}, 2'b10);
                    end else if (TBL[r].kind == K_EMPTY) begin
                        check(ge && !gn && nb == 0, "R10 empty packet", nb, 0);
                    end else begin
                        check(ge && !gn && nb == int'(TBL[r].arg), "R5 packet length",
                              nb, TBL[r].arg);
                        check(bad == 0, "R5 byte order", bad, 0);
                    end
                end
            endcase
            idle(3);
            check(csr_rdata[3:0] == TBL[r].csr, $sformatf("R2 R4 R6 csr row %0d", r),
                  csr_rdata, TBL[r].csr);
            check(irq == TBL[r].irq, $sformatf("R7 irq row %0d", r), irq, TBL[r].irq);
        end

        // R7 mask: completion set but interrupt disabled
        irq_en = 1'b0;
        idle(1);
        check(irq == 1'b0, "R7 masked irq", irq, 0);
        token(nb, ge, gn, bad);
        check(gn && bad == 0, "R9 NAK with mask", gn, 1);

        // R4 short request waits while both banks are committed
        write_bytes(PKT, 1'b0);
        write_bytes(PKT, 1'b0);
        csr_write(4'b0100);
        idle(3);
        check(csr_rdata[3:0] == 4'b0110, "R4 short pending while full", csr_rdata, 4'b0110);
        write_bytes(1, 1'b1);
        idle(2);
        check(csr_rdata[3] == 1'b1, "R11 drop sets overflow", csr_rdata[3], 1);
        token(nb, ge, gn, bad);
        check(ge && nb == PKT && bad == 0, "R5 full packet after refill", nb, PKT);
        idle(3);
        check(csr_rdata[3:0] == 4'b1010, "R4 pending served after free bank",
              csr_rdata, 4'b1010);

        // R1 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        idle(2);
        check(csr_rdata == 8'h01, "R1 csr after second reset", csr_rdata, 8'h01);
        check(irq == 1'b0, "R1 irq after second reset", irq, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule